// File: doc/BRIEF.md
# Serial Character Receiver with Per-Character Error Status

This block takes an asynchronous serial line, recovers characters from it, and holds them until software reads them. A free-running divider makes a tick at sixteen times the bit rate. A framing state machine finds the start of each character, samples every bit at its centre, and builds the character together with its parity-error and frame-error results. Finished characters move into a small queue. Each queue entry keeps its own two error bits, so the status word always describes the character that the next read will return.

If a new frame begins when the queue is full and a finished character is already waiting in the shift stage, the block raises an overflow flag and drops the new frame. All the earlier characters stay available. Software clears the error flags by writing ones to them, or by turning the receiver off. The bits of the status word above the flags always read zero.

The framing state machine has five states. IDLE waits for a high-to-low edge on the line and then goes to START. START checks the line at the centre of the start bit: if it is still low the machine goes to DATA, otherwise it returns to IDLE. DATA takes eight samples, least significant bit first, and then goes to PARITY when parity checking is on, or to STOP when it is off. PARITY takes one sample and goes to STOP. STOP samples the stop bit, hands over the character and returns to IDLE. Turning the receiver off sends any state back to IDLE.

Top module: `uart_rx_stat`

## Requirements
- R1: After reset, `stat_rdata` is 0, `rx_valid` is 0 and `rd_data` is 0.
- R2: A frame is one low start bit, then 8 data bits sent least significant bit first. An even-parity bit follows only when `parity_en` is 1. The frame ends with one stop bit. Each bit lasts 16 ticks, and a tick comes every `TICK_DIV` clocks. The received byte appears on `rd_data` with `rx_valid` high.
- R3: A low pulse on `rxd` that has ended by the centre of the start bit is rejected. The machine returns to IDLE and no character is produced.
- R4: Bit 0 of `stat_rdata` (parity error) is 1 for a character only when `parity_en` is 1 and the data bits plus the parity bit hold an odd number of ones.
- R5: Bit 1 of `stat_rdata` (frame error) is 1 for a character whose stop bit is sampled low. The data byte of that character is still delivered.
- R6: Bits 1 and 0 of `stat_rdata` show the flags of the oldest unread character. They read 0 when no character is waiting.
- R7: Up to three characters are held: two in the queue and one in the shift stage. A pulse on `data_rd` removes the oldest one. `rx_valid` falls only after a read.
- R8: Bit 2 of `stat_rdata` (overflow) is set when a start bit is confirmed while the queue is full and a character is waiting in the shift stage. That new frame is discarded and the three held characters are kept in order.
- R9: A cycle with `stat_wr` high clears each of status bits 2..0 whose bit in `stat_wdata` is 1. A 0 in `stat_wdata` leaves the flag unchanged. Bits 1 and 0 are cleared in the oldest unread character.
- R10: While `rx_en` is 0, all three error flags, including those stored with queued characters, are cleared by the next clock. Queued data bytes stay readable.
- R11: `stat_rdata[15:3]` always reads 0, and writes to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Receiver enable; 0 clears all error flags |
| parity_en | input | 1 | 1 = frames carry an even-parity bit |
| data_rd | input | 1 | Read strobe; removes the oldest character |
| rd_data | output | 8 | Oldest unread character (0 when none) |
| rx_valid | output | 1 | At least one character is waiting |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 16 | Status write data (write-one-to-clear on bits 2..0) |
| stat_rdata | output | 16 | Status word: bit 2 overflow, bit 1 frame error, bit 0 parity error |

## Verification
If the sample counter drifts or the bit counter is wrong, the byte on `rd_data` for the affected frame is wrong. The sweep over all 256 byte values shows this within one frame time. If the shift stage does not hold or release characters correctly, the three characters read back after an overflow come out lost, duplicated or out of order. If an error flag is attached to the wrong entry, the flag shows against the wrong character in the status reads taken just before each data read. If the write-one-to-clear or disable paths fail, a stuck or missing flag shows in the status read taken right after the write or the disable.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
    } rx_char_t;

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     tick,
    input  logic     rxd,
    input  logic     parity_en,
    input  logic     block_new,
    output logic     done,
    output rx_char_t ch,
    output logic     ovf_hit
);
    rx_state_t  state, nxt;
    logic [3:0] samp_cnt;
    logic [2:0] bit_cnt;
    logic [7:0] shreg;
    logic       par_bit;
    logic       discard;
    logic       rxd_q;
    logic       mid;

    assign mid = tick && (samp_cnt == 4'd15);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:   if (rxd_q && !rxd) nxt = RX_START;
            RX_START:  if (tick && samp_cnt == 4'd7) nxt = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:   if (mid && bit_cnt == 3'd7) nxt = parity_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (mid) nxt = RX_STOP;
            RX_STOP:   if (mid) nxt = RX_IDLE;
            default:   nxt = RX_IDLE;
        endcase
        if (!en) nxt = RX_IDLE;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_cnt <= '0;
            bit_cnt  <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            discard  <= 1'b0;
            rxd_q    <= 1'b1;
            done     <= 1'b0;
            ovf_hit  <= 1'b0;
            ch       <= '0;
        end else begin
            rxd_q   <= rxd;
            done    <= 1'b0;
            ovf_hit <= 1'b0;
            if (!en) begin
                samp_cnt <= '0;
                bit_cnt  <= '0;
                discard  <= 1'b0;
            end else begin
                unique case (state)
                    RX_IDLE: begin
                        samp_cnt <= '0;
                        bit_cnt  <= '0;
                    end
                    RX_START: if (tick) begin
                        if (samp_cnt == 4'd7) begin
                            samp_cnt <= '0;
                            if (!rxd) begin
                                discard <= block_new;
                                ovf_hit <= block_new;
                            end
                        end else begin
                            samp_cnt <= samp_cnt + 1'b1;
                        end
                    end
                    RX_DATA: if (tick) begin
                        samp_cnt <= samp_cnt + 1'b1;
                        if (samp_cnt == 4'd15) begin
                            shreg   <= {rxd, shreg[7:1]};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    RX_PARITY: if (tick) begin
                        samp_cnt <= samp_cnt + 1'b1;
                        if (samp_cnt == 4'd15) par_bit <= rxd;
                    end
                    RX_STOP: if (tick) begin
                        samp_cnt <= samp_cnt + 1'b1;
                        if (samp_cnt == 4'd15) begin
                            done    <= !discard;
                            ch.data <= shreg;
                            ch.ferr <= !rxd;
                            ch.perr <= parity_en && ((^shreg) ^ par_bit);
                        end
                    end
                    default: samp_cnt <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  rx_char_t push_ch,
    input  logic     pop,
    input  logic     clr_perr,
    input  logic     clr_ferr,
    input  logic     clr_all,
    output rx_char_t head,
    output logic     empty,
    output logic     full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_char_t      mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] nxt_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (clr_all) begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem[i].perr <= 1'b0;
                    mem[i].ferr <= 1'b0;
                end
            end
            if (!empty && clr_perr) mem[rd_ptr].perr <= 1'b0;
            if (!empty && clr_ferr) mem[rd_ptr].ferr <= 1'b0;
            if (push) begin
                mem[wr_ptr] <= push_ch;
                wr_ptr      <= nxt_ptr(wr_ptr);
            end
            if (pop) rd_ptr <= nxt_ptr(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
    import uart_rx_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int DEPTH    = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rxd,
    input  logic        rx_en,
    input  logic        parity_en,
    input  logic        data_rd,
    output logic [7:0]  rd_data,
    output logic        rx_valid,
    input  logic        stat_wr,
    input  logic [15:0] stat_wdata,
    output logic [15:0] stat_rdata
);
    logic     rxd_s1, rxd_s2;
    logic     tick;
    logic     done, ovf_hit;
    rx_char_t frame_ch, head;
    logic     empty, full;
    logic     hold_v;
    rx_char_t hold_ch;
    logic     push, pop;
    logic     ovf_q;
    logic     unused_wbits;

    assign unused_wbits = ^stat_wdata[15:3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_s1 <= 1'b1;
            rxd_s2 <= 1'b1;
        end else begin
            rxd_s1 <= rxd;
            rxd_s2 <= rxd_s1;
        end
    end

    uart_rx_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    uart_rx_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rx_en),
        .tick     (tick),
        .rxd      (rxd_s2),
        .parity_en(parity_en),
        .block_new(full && hold_v),
        .done     (done),
        .ch       (frame_ch),
        .ovf_hit  (ovf_hit)
    );

    assign push = hold_v && !full;
    assign pop  = data_rd && !empty;

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .push_ch (hold_ch),
        .pop     (pop),
        .clr_perr(stat_wr && stat_wdata[0] && rx_en),
        .clr_ferr(stat_wr && stat_wdata[1] && rx_en),
        .clr_all (!rx_en),
        .head    (head),
        .empty   (empty),
        .full    (full)
    );

    // shift-stage holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_v  <= 1'b0;
            hold_ch <= '0;
        end else begin
            if (done) begin
                hold_v  <= 1'b1;
                hold_ch <= frame_ch;
            end else if (push) begin
                hold_v <= 1'b0;
            end
            if (!rx_en) begin
                hold_ch.perr <= 1'b0;
                hold_ch.ferr <= 1'b0;
            end
        end
    end

    // overflow flag: disable and write-one win over a new event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         ovf_q <= 1'b0;
        else if (!rx_en)                    ovf_q <= 1'b0;
        else if (stat_wr && stat_wdata[2])  ovf_q <= 1'b0;
        else if (ovf_hit)                   ovf_q <= 1'b1;
    end

    assign rx_valid   = !empty;
    assign rd_data    = empty ? 8'h00 : head.data;
    assign stat_rdata = {13'b0, ovf_q, !empty && head.ferr, !empty && head.perr};
endmodule

// File: rtl/uart_rx_stat_chk.sv
module uart_rx_stat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_en,
    input logic        data_rd,
    input logic        stat_wr,
    input logic [15:0] stat_wdata,
    input logic [15:0] stat_rdata,
    input logic        rx_valid
);
    assert_resv_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[15:3] == 13'b0);

    assert_dis_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> stat_rdata[2:0] == 3'b000);

    assert_w1c_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && stat_wr && stat_wdata[2]) |=> !stat_rdata[2]);

    assert_w0_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && stat_rdata[2] && !(stat_wr && stat_wdata[2])) |=> stat_rdata[2]);

    assert_pop_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_valid) |-> $past(data_rd));

    assert_empty_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> stat_rdata[1:0] == 2'b00);

    assert_ovf_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_rdata[2]) |-> rx_valid);
endmodule

bind uart_rx_stat uart_rx_stat_chk u_chk (.*);

// File: tb/uart_rx_stat_tb.sv
module uart_rx_stat_tb;
    localparam int TDIV = 2;
    localparam int BIT  = 16 * TDIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic        rx_en = 1'b1;
    logic        parity_en = 1'b0;
    logic        data_rd = 1'b0;
    logic [7:0]  rd_data;
    logic        rx_valid;
    logic        stat_wr = 1'b0;
    logic [15:0] stat_wdata = '0;
    logic [15:0] stat_rdata;

    int checks = 0;
    int errors = 0;
    bit done_run = 1'b0;

    always #10 clk = ~clk;

    uart_rx_stat #(.TICK_DIV(TDIV), .DEPTH(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_en(rx_en),
        .parity_en(parity_en), .data_rd(data_rd), .rd_data(rd_data),
        .rx_valid(rx_valid), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .stat_rdata(stat_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input bit with_par,
                        input bit bad_par, input bit stop_v);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BIT) @(negedge clk);
        end
        if (with_par) begin
            rxd = (^d) ^ bad_par;
            repeat (BIT) @(negedge clk);
        end
        rxd = stop_v;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic pop_one;
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wr_stat(input logic [15:0] v);
        stat_wdata = v;
        stat_wr = 1'b1;
        @(negedge clk);
        stat_wr = 1'b0;
        stat_wdata = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 stat", stat_rdata, 16'h0);
        check("R1 valid", {15'b0, rx_valid}, 16'h0);
        check("R1 data", {8'h0, rd_data}, 16'h0);

        // R2 sweep of every byte, parity toggled by a value bit
        for (int v = 0; v < 256; v++) begin
            parity_en = v[1];
            send(8'(v), v[1], 1'b0, 1'b1);
            check("R2 valid", {15'b0, rx_valid}, 16'h1);
            check("R2 data", {8'h0, rd_data}, 16'(v));
            check("R4 no perr on good frame", stat_rdata, 16'h0);
            pop_one();
        end
        check("R7 empty after sweep", {15'b0, rx_valid}, 16'h0);

        // R3 short glitch rejected
        rxd = 1'b0;
        repeat (3 * TDIV) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        check("R3 glitch ignored", {15'b0, rx_valid}, 16'h0);

        // R4 parity error, R5 frame error, R6 per-character flags
        parity_en = 1'b1;
        send(8'hA5, 1'b1, 1'b1, 1'b1);
        send(8'h3C, 1'b1, 1'b0, 1'b0);
        check("R4 perr on head", stat_rdata, 16'h0001);
        check("R6 head data", {8'h0, rd_data}, 16'h00A5);
        pop_one();
        check("R5 ferr on next", stat_rdata, 16'h0002);
        check("R5 data kept", {8'h0, rd_data}, 16'h003C);
        pop_one();
        check("R6 empty flags", stat_rdata, 16'h0);

        // R9 write-one-to-clear on head flags
        send(8'h81, 1'b1, 1'b1, 1'b0);
        check("R9 both flags", stat_rdata, 16'h0003);
        wr_stat(16'h0000);
        check("R9 zero write keeps", stat_rdata, 16'h0003);
        wr_stat(16'h0001);
        check("R9 clear perr", stat_rdata, 16'h0002);
        wr_stat(16'h0002);
        check("R9 clear ferr", stat_rdata, 16'h0000);
        pop_one();

        // R7 / R8 overflow with three held characters
        parity_en = 1'b0;
        send(8'h11, 1'b0, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b0, 1'b1);
        send(8'h33, 1'b0, 1'b0, 1'b1);
        check("R8 no ovf yet", stat_rdata, 16'h0);
        send(8'h44, 1'b0, 1'b0, 1'b1);
        check("R8 ovf set", stat_rdata, 16'h0004);
        check("R7 oldest first", {8'h0, rd_data}, 16'h0011);
        pop_one();
        check("R7 second", {8'h0, rd_data}, 16'h0022);
        pop_one();
        check("R7 third from shift stage", {8'h0, rd_data}, 16'h0033);
        pop_one();
        check("R8 new frame dropped", {15'b0, rx_valid}, 16'h0);
        wr_stat(16'h0003);
        check("R9 ovf kept by zero", stat_rdata, 16'h0004);
        wr_stat(16'hFFF8);
        check("R11 reserved write ignored", stat_rdata, 16'h0004);
        wr_stat(16'h0004);
        check("R9 ovf cleared", stat_rdata, 16'h0);

        // R10 disable clears flags, keeps data
        parity_en = 1'b1;
        send(8'h5A, 1'b1, 1'b1, 1'b0);
        check("R10 flags before", stat_rdata, 16'h0003);
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 flags cleared", stat_rdata, 16'h0);
        check("R10 data kept", {8'h0, rd_data}, 16'h005A);
        rx_en = 1'b1;
        @(negedge clk);
        check("R10 still clear", stat_rdata, 16'h0);
        pop_one();
        check("R11 reserved zero", {stat_rdata[15:3], 3'b0}, 16'h0);
        done_run = 1'b1;
    end

    initial begin
        for (int c = 0; c < 180000; c++) begin
            @(posedge clk);
            if (done_run) break;
        end
        if (!done_run) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule